// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire Ethernet PHY management bus. It carries out one register access at a time. The host gives a one-cycle start pulse together with a direction bit, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then produces the management clock and shifts a complete frame out on the data line. On reads it shifts the PHY's reply back in. When the frame ends it pulses `done` for one cycle. After a read it presents the captured register value. If no PHY answered the turnaround, it raises `err` instead.

The management clock is derived from the system clock by a counter. The parameter `HALF_DIV` gives the number of system cycles in each half of the management clock. Its default of 20 keeps the bus at 2.5 MHz when the system clock is 100 MHz. Each bit occupies one management clock period, called a slot below, which is 2*HALF_DIV system cycles long. Each slot opens with the clock low and turns high halfway through. The data line is split into a driven value, an output enable and a sampled input, so that the pad ring can build the tri-state buffer.

Top module: `mdio_master`

## Requirements
- R1: After a start is accepted, the first 32 slots drive the data line high with the output enable set.
- R2: Slots 32 and 33 carry the start code 0 then 1. Slots 34 and 35 carry the opcode: 1,0 for a read (rd_sel=1) and 0,1 for a write (rd_sel=0).
- R3: Slots 36 to 40 carry the PHY address and slots 41 to 45 the register address, each most significant bit first, with the output enable set.
- R4: The management clock is low for the first HALF_DIV system cycles of each slot and high for the next HALF_DIV. The driven data value and the output enable change only while the clock is low, never on the edge that raises it or during the high half.
- R5: On a read, slots 46 and 47 are released (output enable low). The data input is sampled on the system clock edge where the clock rises in slot 47, and a 0 there means a PHY is present.
- R6: On a read where the slot-47 sample is 1, the block releases the line for 32 further slots (slots 48 to 79) and then finishes. At that point it has err=1 and rd_data unchanged from its previous value.
- R7: On a read with a valid turnaround, the data input is sampled at the clock rise of slots 48 to 63, most significant bit first. At completion rd_data holds those 16 bits and err is 0.
- R8: A successful read releases the line in slot 64 and completes after exactly 65 slots.
- R9: On a write, slots 46 and 47 drive 1 then 0, and slots 48 to 63 drive wr_data most significant bit first, all with the output enable set.
- R10: A write releases the line in slot 64, completes after exactly 65 slots, clears err and leaves rd_data unchanged.
- R11: A start pulse while busy is ignored. The frame in progress, including its direction, addresses and data, is unaffected.
- R12: busy is high from the cycle after an accepted start until completion. done pulses for a single cycle, in which busy is already low. rd_data and err change only at that pulse and hold until the next completion.
- R13: After reset the management clock and output enable are low, and busy, done, err and rd_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a transaction (accepted only when idle) |
| rd_sel | input | 1 | 1 selects a read, 0 a write; sampled with start |
| phy_addr | input | 5 | PHY address; sampled with start |
| reg_addr | input | 5 | Register address; sampled with start |
| wr_data | input | 16 | Value to write; sampled with start |
| rd_data | output | 16 | Last successfully read register value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transaction was a read with no PHY response |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Value sampled from the data line |

## Verification
The assertions take for granted that start is a clean synchronous level and that the addresses, direction and write data only need to be valid in the cycle start is accepted. They do not require start to stay low while busy. The bench keeps mdio_i steady from the falling edge of the management clock through the following rising edge, as a PHY would. It also deliberately pulses start mid-frame with altered inputs, so that the ignore and latching behaviour is exercised inside the assumed input envelope.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int PRE_SLOTS   = 32;
  localparam int HDR_SLOTS   = 4 + 2 * ADDR_W;
  localparam int TA_SLOTS    = 2;
  localparam int WR_SLOTS    = TA_SLOTS + DATA_W;
  localparam int RECOV_SLOTS = 32;
  localparam int FRAME_W     = HDR_SLOTS + WR_SLOTS;
  localparam int CNT_W       = $clog2(PRE_SLOTS) + 1;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_DRIVE = 2'b10;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_HDR,
    PH_WDAT,
    PH_TA,
    PH_RDAT,
    PH_TAIL,
    PH_RECOV
  } phase_e;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic slot_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          wrap;

  assign wrap = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign mdc      = ph_q;
  assign rise_tk  = wrap && !ph_q;
  assign slot_end = wrap && ph_q;
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] phy_ad,
  input  logic [ADDR_W-1:0] reg_ad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  input  logic              rise_tk,
  input  logic              slot_end,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_PRE   = CNT_W'(PRE_SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_HDR   = CNT_W'(HDR_SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_WR    = CNT_W'(WR_SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_TA    = CNT_W'(TA_SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_RD    = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_RECOV = CNT_W'(RECOV_SLOTS - 1);

  phase_e             st_q, st_d;
  logic [CNT_W-1:0]   bcnt_q, bcnt_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               rd_q, rd_d;
  logic               ta_q, ta_d;
  logic               mdo_q, mdo_d;
  logic               oe_q, oe_d;
  logic               err_q, err_d;
  logic               done_q, done_d;

  always_comb begin
    st_d    = st_q;
    bcnt_d  = bcnt_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    rdata_d = rdata_q;
    rd_d    = rd_q;
    ta_d    = ta_q;
    mdo_d   = mdo_q;
    oe_d    = oe_q;
    err_d   = err_q;
    done_d  = 1'b0;

    if (st_q == PH_IDLE) begin
      if (start) begin
        st_d   = PH_PRE;
        bcnt_d = '0;
        rd_d   = rd_sel;
        tx_d   = {SOF_CODE, (rd_sel ? OP_READ : OP_WRITE), phy_ad, reg_ad, TA_DRIVE, wdata};
        mdo_d  = 1'b1;
        oe_d   = 1'b1;
      end
    end else begin
      if (rise_tk) begin
        if ((st_q == PH_TA) && (bcnt_q == LAST_TA)) begin
          ta_d = mdio_i;
        end
        if (st_q == PH_RDAT) begin
          rx_d = {rx_q[DATA_W-2:0], mdio_i};
        end
      end

      if (slot_end) begin
        case (st_q)
          PH_PRE: begin
            if (bcnt_q == LAST_PRE) begin
              st_d   = PH_HDR;
              bcnt_d = '0;
              mdo_d  = tx_q[FRAME_W-1];
              tx_d   = {tx_q[FRAME_W-2:0], 1'b0};
            end else begin
              bcnt_d = bcnt_q + ONE;
            end
          end
          PH_HDR: begin
            if (bcnt_q == LAST_HDR) begin
              bcnt_d = '0;
              if (rd_q) begin
                st_d = PH_TA;
                oe_d = 1'b0;
              end else begin
                st_d  = PH_WDAT;
                mdo_d = tx_q[FRAME_W-1];
                tx_d  = {tx_q[FRAME_W-2:0], 1'b0};
              end
            end else begin
              bcnt_d = bcnt_q + ONE;
              mdo_d  = tx_q[FRAME_W-1];
              tx_d   = {tx_q[FRAME_W-2:0], 1'b0};
            end
          end
          PH_WDAT: begin
            if (bcnt_q == LAST_WR) begin
              st_d   = PH_TAIL;
              bcnt_d = '0;
              oe_d   = 1'b0;
            end else begin
              bcnt_d = bcnt_q + ONE;
              mdo_d  = tx_q[FRAME_W-1];
              tx_d   = {tx_q[FRAME_W-2:0], 1'b0};
            end
          end
          PH_TA: begin
            if (bcnt_q == LAST_TA) begin
              bcnt_d = '0;
              st_d   = ta_q ? PH_RECOV : PH_RDAT;
            end else begin
              bcnt_d = bcnt_q + ONE;
            end
          end
          PH_RDAT: begin
            if (bcnt_q == LAST_RD) begin
              st_d   = PH_TAIL;
              bcnt_d = '0;
            end else begin
              bcnt_d = bcnt_q + ONE;
            end
          end
          PH_TAIL: begin
            st_d   = PH_IDLE;
            oe_d   = 1'b0;
            done_d = 1'b1;
            err_d  = 1'b0;
            if (rd_q) begin
              rdata_d = rx_q;
            end
          end
          PH_RECOV: begin
            if (bcnt_q == LAST_RECOV) begin
              st_d   = PH_IDLE;
              bcnt_d = '0;
              done_d = 1'b1;
              err_d  = 1'b1;
            end else begin
              bcnt_d = bcnt_q + ONE;
            end
          end
          default: begin
            st_d = PH_IDLE;
            oe_d = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      bcnt_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      rd_q    <= 1'b0;
      ta_q    <= 1'b0;
      mdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      bcnt_q  <= bcnt_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      rdata_q <= rdata_d;
      rd_q    <= rd_d;
      ta_q    <= ta_d;
      mdo_q   <= mdo_d;
      oe_q    <= oe_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (st_q != PH_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign rd_data = rdata_q;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic rst_sn;
  logic rise_tk;
  logic slot_end;

  mdio_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run      (busy),
    .mdc      (mdc),
    .rise_tk  (rise_tk),
    .slot_end (slot_end)
  );

  mdio_frame_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start    (start),
    .rd_sel   (rd_sel),
    .phy_ad   (phy_addr),
    .reg_ad   (reg_addr),
    .wdata    (wr_data),
    .mdio_i   (mdio_i),
    .rise_tk  (rise_tk),
    .slot_end (slot_end),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rd_data  (rd_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R1: an accepted start opens the preamble with the line driven high
  p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && mdio_oe && mdio_o && !mdc));

  // R4: line value and enable never move while the clock is high
  p_stable_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R4: the clock only toggles inside a transaction
  p_rise_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);

  // R13: idle bus is quiet
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R12: done is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: done closes a busy period
  p_done_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R12: results move only with done
  p_hold_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rd_data) && $stable(err)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .rd_data (rd_data),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int H = 3;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        rd_sel;
  logic [4:0]  phy_addr;
  logic [4:0]  reg_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        busy;
  logic        done;
  logic        err;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int          n_tests;
  int          n_fail;
  logic [15:0] exp_rdata;
  logic        exp_err;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  mdio_master #(.HALF_DIV(H)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_sel   (rd_sel),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .mdio_i   (mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // PHY model: value presented on the data input during slot k
  function automatic logic phy_bit(input int k, input bit rd, input bit absent,
                                   input logic [15:0] pd);
    if (!rd) return 1'b1;
    if (k == 47) return absent;
    if (k >= 48 && k < 64) return pd[15 - (k - 48)];
    return 1'b1;
  endfunction

  task automatic run_txn(input bit rd, input bit absent, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] wd,
                         input logic [15:0] pd, input int ign);
    int          n;
    int          pre_cnt;
    int          hdr_oe_bad;
    int          wr_oe_bad;
    int          ta_bad;
    int          rel_bad;
    int          tail_bad;
    int          ph_bad;
    int          bsy_bad;
    logic [13:0] hdr_act;
    logic [17:0] wr_act;
    logic        lo_o;
    logic        lo_oe;
    bit          fin_ok;
    pre_cnt = 0; hdr_oe_bad = 0; wr_oe_bad = 0; ta_bad = 0; rel_bad = 0;
    tail_bad = 0; ph_bad = 0; bsy_bad = 0; hdr_act = '0; wr_act = '0;

    chk(rd_data === exp_rdata && err === exp_err, "R12", "result held until next start",
        {15'd0, err, rd_data}, {15'd0, exp_err, exp_rdata});

    @(negedge clk);
    start = 1'b1; rd_sel = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    @(negedge clk);
    start = 1'b0; rd_sel = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;

    n = (rd && absent) ? 80 : 65;
    for (int k = 0; k < n; k++) begin
      lo_o  = mdio_o;
      lo_oe = mdio_oe;
      if (mdc !== 1'b0) ph_bad++;
      if (busy !== 1'b1 || done !== 1'b0) bsy_bad++;
      mdio_i = phy_bit(k, rd, absent, pd);
      if (k == ign) begin
        start    = 1'b1;
        rd_sel   = 1'($urandom_range(1, 0));
        phy_addr = 5'($urandom);
        wr_data  = 16'($urandom);
      end
      for (int i = 0; i < H; i++) begin
        @(negedge clk);
        if (i == 0) start = 1'b0;
      end
      if (mdc !== 1'b1 || mdio_o !== lo_o || mdio_oe !== lo_oe) ph_bad++;
      if (busy !== 1'b1 || done !== 1'b0) bsy_bad++;
      for (int i = 0; i < H; i++) @(negedge clk);
      if (k < 32) begin
        if (lo_oe && lo_o) pre_cnt++;
      end else if (k < 46) begin
        hdr_act = {hdr_act[12:0], lo_o};
        if (!lo_oe) hdr_oe_bad++;
      end else if (k < 64) begin
        if (rd) begin
          if (k < 48) begin
            if (lo_oe) ta_bad++;
          end else if (lo_oe) rel_bad++;
        end else begin
          wr_act = {wr_act[16:0], lo_o};
          if (!lo_oe) wr_oe_bad++;
        end
      end else begin
        if (lo_oe) tail_bad++;
      end
    end
    fin_ok = (done === 1'b1) && (busy === 1'b0);

    chk(pre_cnt == 32, "R1", "preamble slots driven high", pre_cnt, 32);
    chk(hdr_act[13:10] == {2'b01, (rd ? 2'b10 : 2'b01)}, "R2", "start and opcode",
        {28'd0, hdr_act[13:10]}, {28'd0, 2'b01, (rd ? 2'b10 : 2'b01)});
    chk(hdr_act[9:0] == {pa, ra} && hdr_oe_bad == 0, "R3", "addresses",
        {22'd0, hdr_act[9:0]}, {22'd0, pa, ra});
    chk(ph_bad == 0, "R4", "clock phases and stable line", ph_bad, 0);
    chk(bsy_bad == 0 && fin_ok, "R12", "busy through frame, done at end",
        {bsy_bad[30:0], fin_ok}, 32'd1);
    if (rd) begin
      chk(ta_bad == 0, "R5", "turnaround released", ta_bad, 0);
      if (absent) begin
        chk(fin_ok && rel_bad == 0 && tail_bad == 0 && err === 1'b1 && rd_data === exp_rdata,
            "R6", "absent PHY recovery and error", {15'd0, err, rd_data}, {15'd0, 1'b1, exp_rdata});
        exp_err = 1'b1;
      end else begin
        chk(rd_data === pd && err === 1'b0 && rel_bad == 0, "R7", "read data captured",
            {15'd0, err, rd_data}, {16'd0, pd});
        chk(fin_ok && tail_bad == 0, "R8", "read tail and 65-slot length", tail_bad, 0);
        exp_rdata = pd;
        exp_err   = 1'b0;
      end
    end else begin
      chk(wr_act == {2'b10, wd} && wr_oe_bad == 0, "R9", "write turnaround and data",
          {14'd0, wr_act}, {14'd0, 2'b10, wd});
      chk(fin_ok && tail_bad == 0 && err === 1'b0 && rd_data === exp_rdata, "R10",
          "write tail, length and flags", {15'd0, err, rd_data}, {16'd0, exp_rdata});
      exp_err = 1'b0;
    end
    if (ign >= 0) begin
      chk(pre_cnt == 32 && hdr_act[9:0] == {pa, ra} && ph_bad == 0 && fin_ok, "R11",
          "start while busy ignored", {22'd0, hdr_act[9:0]}, {22'd0, pa, ra});
    end
    @(negedge clk);
    chk(done === 1'b0, "R12", "done lasts one cycle", {31'd0, done}, 32'd0);
    mdio_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    exp_rdata = '0; exp_err = 1'b0;
    void'($urandom(32'd7741));
    rst_n = 1'b0; start = 1'b0; rd_sel = 1'b0; phy_addr = '0; reg_addr = '0;
    wr_data = '0; mdio_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13: reset state
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R13", "bus idle after reset",
        {30'd0, mdc, mdio_oe}, 32'd0);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && rd_data === 16'h0000, "R13",
        "flags and data after reset", {13'd0, busy, done, err, rd_data}, 32'd0);

    // directed corners
    run_txn(1'b0, 1'b0, 5'h1F, 5'h00, 16'hA55A, 16'h0000, -1);
    run_txn(1'b1, 1'b0, 5'h00, 5'h1F, 16'h0000, 16'h8001, -1);
    run_txn(1'b1, 1'b1, 5'h15, 5'h0A, 16'h0000, 16'h1234, -1);
    run_txn(1'b1, 1'b0, 5'h0A, 5'h15, 16'h0000, 16'hFFFF, -1);
    run_txn(1'b0, 1'b0, 5'h03, 5'h11, 16'h0000, 16'h0000, 20);
    run_txn(1'b1, 1'b0, 5'h11, 5'h03, 16'h0000, 16'h0F0F, 50);
    run_txn(1'b1, 1'b1, 5'h07, 5'h07, 16'h0000, 16'hBEEF, 70);

    // random mix
    for (int t = 0; t < 16; t++) begin
      bit rd;
      bit absent;
      int ign;
      rd     = 1'($urandom_range(1, 0));
      absent = rd && ($urandom_range(3, 0) == 0);
      ign    = ($urandom_range(2, 0) == 0) ? int'($urandom_range(60, 1)) : -1;
      repeat ($urandom_range(4, 0)) @(negedge clk);
      run_txn(rd, absent, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), ign);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule